// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block scans a key matrix of up to sixteen rows by sixteen columns. It drives one row select at a time and waits a programmable settle time. It then samples the column inputs and stores them as one 16-bit word per row. Software configures and reads it through a small APB-style register window. The columns are active-low, so a pressed key reads as 0 in the stored word.

There are four operating modes. Idle does nothing. Detect raises every row select together and flags any key press without touching the stored words. Single scan sweeps the configured rows once and then returns the mode field to idle by itself. Continuous scan sweeps, waits a programmable gap, and sweeps again. Three sticky event flags (scan complete, data changed, key pressed in detect mode) are cleared by writing 1 and gated by a mask onto one interrupt line.

Top module: `kpscan_top`

## Requirements
- R1: After reset, the control (0x00), geometry (0x04), status (0x08), mask (0x0C) and row data (0x10 onward) registers read 0, no row select is driven, and the interrupt is low.
- R2: Control bits 1:0 set the mode: 0 idle, 1 detect, 2 single, 3 continuous. In single mode, rows 0 to count-1 are selected one at a time in ascending order. After the last row is sampled, the mode field reads 0 and status bit 0 (scan complete) is set.
- R3: In continuous mode, after the last row is sampled no row is selected for gap+1 cycles, where gap is control bits 31:16, and then a new sweep starts at row 0. The mode field stays 3 until software changes it. Writing mode 0 stops the sweep.
- R4: Each selected row stays selected for settle+1 cycles, where settle is control bits 15:2, and is sampled in its last cycle.
- R5: Geometry bits 7:0 give the number of rows swept. Rows at or above that count keep their previous data.
- R6: Geometry bits 15:8 give the number of active columns. In every updated row, column bits at or above that count are stored as 1. In detect mode a low level on such a column is not counted as a press.
- R7: Status bit 1 (data changed) sets when a row word written during a sweep differs from the value it replaces. It does not set when the sweep writes identical data.
- R8: In detect mode all row selects are driven high and no row data is written. Status bit 2 sets while any active column reads low. Writing 1 to bit 2 does not clear it while the key is held, and does clear it after release.
- R9: Status bits are sticky and cleared only by writing 1 to them; writing 0 leaves them unchanged. The interrupt is high exactly when a status bit and its mask bit (0x0C, same bit positions) are both set.
- R10: Row data is read two rows per 32-bit word starting at 0x10. Row 2k sits in bits 15:0 and row 2k+1 in bits 31:16 of the word at 0x10+4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and scan clock |
| rstN | input | 1 | Active-low reset |
| psel | input | 1 | Register window select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| rowSel | output | 16 | Row select lines, active-high |
| colIn | input | 16 | Column sense lines, active-low |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench models a real matrix: each column input is the AND of the key patterns of all selected rows. Single sweeps are run with keys pressed inside and outside the active column and row counts. This separates correct masking from wrong masking and correct row limits from overwriting rows beyond the count. A repeated sweep over unchanged keys separates a true change detector from one that fires on every write. A continuous sweep with a key changed between passes exercises restart, gap length and the change flag. In detect mode, presses are applied and released around clear attempts to show the sticky hold, and a press on an inactive column shows that the column limit applies there too. A scoreboard checks the order of row selection and how long each row is held.

// File: rtl/kpscan_pkg.sv
package kpscan_pkg;
  parameter int unsigned MAX_ROWS  = 16;
  parameter int unsigned COL_W     = 16;
  parameter int unsigned ROW_IDX_W = $clog2(MAX_ROWS);
  parameter int unsigned CNT8_W    = 8;
  parameter int unsigned SETTLE_W  = 14;
  parameter int unsigned GAP_W     = 16;
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned DATA_W    = 2 * COL_W;

  localparam int unsigned WORD_CTRL  = 0;
  localparam int unsigned WORD_GEOM  = 1;
  localparam int unsigned WORD_STAT  = 2;
  localparam int unsigned WORD_MASK  = 3;
  localparam int unsigned WORD_DATA0 = 4;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_DETECT = 2'd1,
    MODE_ONCE   = 2'd2,
    MODE_LOOP   = 2'd3
  } scanMode_e;

  typedef struct packed {
    logic                 rowWr;
    logic [ROW_IDX_W-1:0] rowIdx;
    logic                 scanDone;
    logic                 modeClear;
  } scanStb_t;
endpackage

// File: rtl/kpscan_ctrl.sv
module kpscan_ctrl
  import kpscan_pkg::*;
#(
  parameter int unsigned ROWS  = MAX_ROWS,
  parameter int unsigned SET_W = SETTLE_W,
  parameter int unsigned GW    = GAP_W,
  parameter int unsigned RCW   = CNT8_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanMode_e        mode,
  input  logic [SET_W-1:0] settle,
  input  logic [GW-1:0]    gap,
  input  logic [RCW-1:0]   rowCount,
  output scanStb_t         stb,
  output logic [ROWS-1:0]  rowSel
);
  localparam int unsigned CNT_W = (SET_W > GW) ? SET_W : GW;
  localparam int unsigned IDX_W = $clog2(ROWS);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_GAP} scanState_e;

  scanState_e       st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [IDX_W-1:0] rowIdx, idxNext;
  logic [RCW-1:0]   effRows, lastRow;
  logic             scanning, detectAll;

  assign scanning  = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign detectAll = (mode == MODE_DETECT);
  assign effRows   = (rowCount > RCW'(ROWS)) ? RCW'(ROWS) : rowCount;
  assign lastRow   = effRows - RCW'(1);

  always_comb begin
    stb        = '0;
    stb.rowIdx = rowIdx;
    stNext     = st;
    cntNext    = cnt;
    idxNext    = rowIdx;
    case (st)
      ST_IDLE: begin
        if (scanning) begin
          cntNext = '0;
          idxNext = '0;
          if (effRows == '0) begin
            stb.scanDone = 1'b1;
            if (mode == MODE_ONCE) stb.modeClear = 1'b1;
            else                   stNext = ST_GAP;
          end else begin
            stNext = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (!scanning) begin
          stNext = ST_IDLE;
        end else if (cnt == CNT_W'(settle)) begin
          stb.rowWr = 1'b1;
          cntNext   = '0;
          if (RCW'(rowIdx) == lastRow) begin
            stb.scanDone = 1'b1;
            if (mode == MODE_ONCE) begin
              stb.modeClear = 1'b1;
              stNext        = ST_IDLE;
            end else begin
              stNext = ST_GAP;
            end
          end else begin
            idxNext = rowIdx + IDX_W'(1);
          end
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end
      default: begin
        if (!scanning) begin
          stNext = ST_IDLE;
        end else if (cnt == CNT_W'(gap)) begin
          stNext  = ST_SETTLE;
          cntNext = '0;
          idxNext = '0;
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      st     <= stNext;
      cnt    <= cntNext;
      rowIdx <= idxNext;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowSel
    assign rowSel[r] = detectAll || ((st == ST_SETTLE) && (rowIdx == IDX_W'(r)));
  end
endmodule

// File: rtl/kpscan_regs.sv
module kpscan_regs
  import kpscan_pkg::*;
#(
  parameter int unsigned ROWS = MAX_ROWS,
  parameter int unsigned CW   = COL_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned RCW  = CNT8_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [AW-1:0]       paddr,
  input  logic [DW-1:0]       pwdata,
  output logic [DW-1:0]       prdata,
  input  logic [CW-1:0]       colIn,
  input  scanStb_t            stb,
  output scanMode_e           mode,
  output logic [SETTLE_W-1:0] settle,
  output logic [GAP_W-1:0]    gap,
  output logic [RCW-1:0]      rowCount,
  output logic                irq,
  output logic [2:0]          statusBits,
  output logic                keyDown,
  output logic                ctrlWrite
);
  localparam int unsigned WA_W  = AW - 2;
  localparam int unsigned PAIRS = ROWS / 2;

  logic [DW-1:0]   ctrlReg;
  logic [2*RCW-1:0] geomReg;
  logic [2:0]      maskReg, setBits, clrBits;
  logic [CW-1:0]   rowData [ROWS];
  logic [CW-1:0]   colMask, newWord;
  logic [WA_W-1:0] wordAddr;
  logic            aligned, busWr;
  logic [RCW-1:0]  colCount;

  assign wordAddr = paddr[AW-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign busWr    = psel && penable && pwrite && aligned;
  assign ctrlWrite = busWr && (wordAddr == WA_W'(WORD_CTRL));

  assign mode     = scanMode_e'(ctrlReg[1:0]);
  assign settle   = ctrlReg[SETTLE_W+1:2];
  assign gap      = ctrlReg[DW-1:DW-GAP_W];
  assign rowCount = geomReg[RCW-1:0];
  assign colCount = geomReg[2*RCW-1:RCW];

  for (genvar c = 0; c < CW; c++) begin : g_colMask
    assign colMask[c] = (RCW'(c) < colCount);
  end

  assign newWord = colIn | ~colMask;
  assign keyDown = |(~colIn & colMask);

  assign setBits = {(mode == MODE_DETECT) && keyDown,
                    stb.rowWr && (newWord != rowData[stb.rowIdx]),
                    stb.scanDone};
  assign clrBits = (busWr && (wordAddr == WA_W'(WORD_STAT))) ? pwdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      geomReg    <= '0;
      maskReg    <= '0;
      statusBits <= '0;
    end else begin
      if (ctrlWrite)          ctrlReg <= pwdata;
      else if (stb.modeClear) ctrlReg[1:0] <= MODE_IDLE;
      if (busWr && (wordAddr == WA_W'(WORD_GEOM))) geomReg <= pwdata[2*RCW-1:0];
      if (busWr && (wordAddr == WA_W'(WORD_MASK))) maskReg <= pwdata[2:0];
      statusBits <= (statusBits & ~clrBits) | setBits;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowStore
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          rowData[r] <= '0;
      else if (stb.rowWr && (stb.rowIdx == ROW_IDX_W'(r))) rowData[r] <= newWord;
    end
  end

  assign irq = |(statusBits & maskReg);

  always_comb begin
    prdata = '0;
    if (aligned) begin
      case (wordAddr)
        WA_W'(WORD_CTRL): prdata = ctrlReg;
        WA_W'(WORD_GEOM): prdata = DW'(geomReg);
        WA_W'(WORD_STAT): prdata = DW'(statusBits);
        WA_W'(WORD_MASK): prdata = DW'(maskReg);
        default: begin
          for (int p = 0; p < PAIRS; p++) begin
            if (wordAddr == WA_W'(WORD_DATA0 + p)) prdata = {rowData[2*p+1], rowData[2*p]};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/kpscan_top.sv
module kpscan_top
  import kpscan_pkg::*;
#(
  parameter int unsigned ROWS = MAX_ROWS,
  parameter int unsigned CW   = COL_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic [ROWS-1:0] rowSel,
  input  logic [CW-1:0] colIn,
  output logic          irq
);
  scanStb_t            stb;
  scanMode_e           curMode;
  logic [SETTLE_W-1:0] settle;
  logic [GAP_W-1:0]    gap;
  logic [CNT8_W-1:0]   rowCount;
  logic [2:0]          statusBits;
  logic                keyDown, ctrlWrite;

  kpscan_regs #(.ROWS(ROWS), .CW(CW), .AW(AW), .DW(DW), .RCW(CNT8_W)) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .colIn(colIn), .stb(stb),
    .mode(curMode), .settle(settle), .gap(gap), .rowCount(rowCount), .irq(irq),
    .statusBits(statusBits), .keyDown(keyDown), .ctrlWrite(ctrlWrite)
  );

  kpscan_ctrl #(.ROWS(ROWS), .SET_W(SETTLE_W), .GW(GAP_W), .RCW(CNT8_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(curMode), .settle(settle), .gap(gap),
    .rowCount(rowCount), .stb(stb), .rowSel(rowSel)
  );
endmodule

// File: rtl/kpscan_chk.sv
module kpscan_chk #(
  parameter int unsigned ROWS = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      mode,
  input logic [ROWS-1:0] rowSel,
  input logic [2:0]      stat,
  input logic            keyDown,
  input logic            ctrlWrite,
  input logic            rowWr
);
  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1) |-> $onehot0(rowSel));

  assert_once_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 2'd2 && mode == 2'd0 && !$past(ctrlWrite)) |-> stat[0]);

  assert_change_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[1]) |-> $past(rowWr));

  assert_press_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stat[2] && keyDown && mode == 2'd1) |=> stat[2]);

  assert_detect_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    rowWr |-> (mode == 2'd2 || mode == 2'd3));
endmodule

bind kpscan_top kpscan_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .mode(curMode), .rowSel(rowSel), .stat(statusBits),
  .keyDown(keyDown), .ctrlWrite(ctrlWrite), .rowWr(stb.rowWr)
);

// File: tb/kpscan_top_tb.sv
module kpscan_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_GEOM = 8'h04, A_STAT = 8'h08,
                         A_MASK = 8'h0C, A_D01 = 8'h10, A_D23 = 8'h14, A_D45 = 8'h18;

  logic clk = 1'b0, rstN = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [15:0] rowSel, colIn;
  logic irq;
  logic [15:0] keyMap [16];

  int total = 0, fails = 0;
  int expQ[$];
  logic [15:0] prevSel = '0;
  int runLen = 0, lastIdleRun = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kpscan_top u_dut (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rowSel(rowSel), .colIn(colIn), .irq(irq));

  always_comb begin
    colIn = '1;
    for (int r = 0; r < 16; r++) if (rowSel[r]) colIn = colIn & keyMap[r];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected {row index, hold cycles} per row activation (R2, R4)
  always @(negedge clk) begin
    if (rstN) begin
      if (rowSel != prevSel) begin
        if ($onehot(prevSel) && expQ.size() > 0) begin
          int idx = 0;
          int exp;
          for (int r = 0; r < 16; r++) if (prevSel[r]) idx = r;
          exp = expQ.pop_front();
          check("R2/R4 row order and hold", 32'((idx << 16) | runLen), 32'(exp));
        end
        if (prevSel == '0 && rowSel != '0) lastIdleRun = runLen;
        runLen = 1;
      end else begin
        runLen++;
      end
      prevSel = rowSel;
    end
  end

  task automatic pushSweep(input int rows, input int settle);
    for (int r = 0; r < rows; r++) expQ.push_back((r << 16) | (settle + 1));
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic waitDone();
    logic [31:0] d;
    for (int i = 0; i < 1000; i++) begin
      busRead(A_STAT, d);
      if (d[0]) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) keyMap[r] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rowSel", 32'(rowSel), 0);
    check("R1 irq", 32'(irq), 0);
    readCheck("R1 ctrl", A_CTRL, 0);
    readCheck("R1 geom", A_GEOM, 0);
    readCheck("R1 status", A_STAT, 0);
    readCheck("R1 mask", A_MASK, 0);
    readCheck("R1 data", A_D01, 0);

    // single sweep: 4 rows, 10 columns, settle 3
    keyMap[0] = 16'hFFFE; keyMap[1] = 16'hFDFF; keyMap[2] = 16'hFBFF;
    keyMap[3] = 16'h7FFF; keyMap[4] = 16'hFFF0;
    busWrite(A_GEOM, 32'h0A04);
    busWrite(A_MASK, 32'h1);
    pushSweep(4, 3);
    busWrite(A_CTRL, (32'd5 << 16) | (32'd3 << 2) | 32'd2);
    waitDone();
    readCheck("R2 mode self-clears", A_CTRL, (32'd5 << 16) | (32'd3 << 2));
    readCheck("R2/R7 status done+changed", A_STAT, 32'h3);
    check("R9 irq with mask", 32'(irq), 1);
    readCheck("R10/R6 rows 0,1", A_D01, 32'hFDFF_FFFE);
    readCheck("R6 rows 2,3 inactive columns read 1", A_D23, 32'hFFFF_FFFF);
    readCheck("R5 row 4 untouched", A_D45, 32'h0);
    check("R2/R4 all rows seen", 32'(expQ.size()), 0);

    // R9 mask and write-1-to-clear
    busWrite(A_MASK, 32'h0);
    @(negedge clk);
    check("R9 irq masked", 32'(irq), 0);
    busWrite(A_STAT, 32'h0);
    readCheck("R9 write 0 keeps status", A_STAT, 32'h3);
    busWrite(A_STAT, 32'h1);
    readCheck("R9 clear bit 0 only", A_STAT, 32'h2);
    busWrite(A_STAT, 32'h2);
    readCheck("R9 all clear", A_STAT, 32'h0);

    // R7 unchanged sweep leaves changed flag clear
    pushSweep(4, 3);
    busWrite(A_CTRL, (32'd3 << 2) | 32'd2);
    waitDone();
    readCheck("R7 no change flag", A_STAT, 32'h1);
    busWrite(A_STAT, 32'h7);

    // R3 continuous: 2 rows, settle 1, gap 40
    busWrite(A_GEOM, 32'h0A02);
    pushSweep(2, 1); pushSweep(2, 1);
    busWrite(A_CTRL, (32'd40 << 16) | (32'd1 << 2) | 32'd3);
    waitDone();
    keyMap[1] = 16'hFFF7;
    busWrite(A_STAT, 32'h7);
    waitDone();
    readCheck("R3 mode stays 3", A_CTRL, (32'd40 << 16) | (32'd1 << 2) | 32'd3);
    readCheck("R3/R7 second sweep changed", A_STAT, 32'h3);
    check("R3 gap length", 32'(lastIdleRun), 32'd41);
    readCheck("R3 new row data", A_D01, 32'hFFF7_FFFE);
    busWrite(A_CTRL, 32'h0);
    repeat (2) @(negedge clk);
    check("R3 stop on mode 0", 32'(rowSel), 0);
    readCheck("R5 rows 2,3 kept", A_D23, 32'hFFFF_FFFF);
    check("R3 queue drained", 32'(expQ.size()), 0);
    expQ.delete();

    // R8 detect mode
    busWrite(A_STAT, 32'h7);
    busWrite(A_GEOM, 32'h0A04);
    busWrite(A_MASK, 32'h4);
    for (int r = 0; r < 16; r++) keyMap[r] = 16'hFFFF;
    busWrite(A_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    check("R8 all rows driven", 32'(rowSel), 32'hFFFF);
    readCheck("R8 no press yet", A_STAT, 32'h0);
    keyMap[2] = 16'hFFEF;
    repeat (2) @(negedge clk);
    readCheck("R8 press flagged", A_STAT, 32'h4);
    check("R9 irq on press", 32'(irq), 1);
    busWrite(A_STAT, 32'h4);
    readCheck("R8 clear ignored while held", A_STAT, 32'h4);
    keyMap[2] = 16'hFFFF;
    busWrite(A_STAT, 32'h4);
    readCheck("R8 clear after release", A_STAT, 32'h0);
    keyMap[1] = 16'hEFFF;
    repeat (3) @(negedge clk);
    readCheck("R6 inactive column press ignored", A_STAT, 32'h0);
    readCheck("R8 data not updated", A_D01, 32'hFFF7_FFFE);
    busWrite(A_CTRL, 32'h0);

    finished = 1;
    summary();
  end
endmodule